// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block sits between the decode stage and the fetch stage of a 16-bit-instruction RISC core. It recognizes the branch group of the instruction set and works out the address fetch reads next. The branch group covers conditional branches on the single T flag, in immediate and delayed forms. It also covers PC-relative unconditional branches and calls, register-indirect jumps and calls, PC-plus-register branches and calls, return from subroutine, return from exception, and a software trap. Any other instruction simply advances fetch by two bytes.

A delayed branch computes its target in the cycle it is accepted, from the register values present in that cycle. It parks that target in a one-entry pending register. The next accepted instruction is the delay slot. Once it is accepted, fetch is redirected to the parked target. A call writes the link value PC+4 through the procedure-register write port. A trap produces a request carrying the trap value (immediate times four), a fixed exception code and a fixed vector offset. Exception entry itself is handled elsewhere. A branch-group instruction found in a delay slot is flagged as illegal and has no architectural effect.

Top module: `bnp_unit`

## Requirements
- R1: After reset `fetch_pc_o` equals `RESET_PC` (default 0xA000_0000), nothing is pending, and `pr_we_o`, `trap_req_o` and `slot_illegal_o` are low.
- R2: An accepted instruction outside the branch group makes `fetch_pc_o` equal `pc_i`+2 in the next cycle.
- R3: Immediate conditional branches, 0x8Bdd (taken when T=0) and 0x89dd (taken when T=1), with `dd` an 8-bit signed displacement in bits 7:0. When taken, `fetch_pc_o` becomes `pc_i`+4+2·sext(dd) in the next cycle. When not taken, it becomes `pc_i`+2.
- R4: Delayed conditional branches, 0x8Fdd (T=0) and 0x8Ddd (T=1), use the same target. When taken, fetch first becomes `pc_i`+2. After the next accepted instruction (the delay slot), fetch becomes the target. When not taken, the unit behaves as in R2.
- R5: 0xAddd is an unconditional delayed branch to `pc_i`+4+2·sext(ddd), with ddd the 12 bits 11:0. 0xBddd branches the same way, and in its cycle it also asserts `pr_we_o` with `pr_wdata_o` = `pc_i`+4.
- R6: 0x0n23 is a delayed branch to `rn_val_i`+`pc_i`+4. 0x0n03 does the same and also writes PR = `pc_i`+4. For every instruction, `rn_sel_o` equals bits 11:8.
- R7: 0x4n2B is a delayed jump to `rn_val_i`. 0x4n0B does the same and also writes PR = `pc_i`+4.
- R8: 0x000B is a delayed return to `pr_i`. 0x002B is a delayed return to `spc_i`.
- R9: A delayed target uses `rn_val_i`, `pr_i` and `spc_i` as sampled in the branch's own cycle. Changes to them during the delay slot do not alter where fetch goes.
- R10: 0xC3ii asserts `trap_req_o` in its cycle, with `trap_tra_o` = ii·4, `trap_code_o` = 0x160 and `trap_vec_o` = 0x100. Fetch advances by 2.
- R11: A branch-group instruction (any encoding in R3–R8 or R10) accepted as a delay slot asserts `slot_illegal_o`. It raises no PR write and no trap, and queues no new target. Fetch still goes to the pending target.
- R12: While `insn_valid_i` is low, `fetch_pc_o` and any pending target are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_valid_i | input | 1 | Instruction accepted this cycle |
| insn_i | input | 16 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| t_i | input | 1 | T flag |
| rn_val_i | input | XLEN | Value of the register selected by `rn_sel_o` |
| pr_i | input | XLEN | Procedure register |
| spc_i | input | XLEN | Saved PC for exception return |
| rn_sel_o | output | 4 | Register index taken from bits 11:8 |
| fetch_pc_o | output | XLEN | Next fetch address |
| pr_we_o | output | 1 | Procedure register write enable |
| pr_wdata_o | output | XLEN | Link value |
| trap_req_o | output | 1 | Trap exception request |
| trap_tra_o | output | XLEN | Trap value, immediate times four |
| trap_code_o | output | 12 | Exception code of the trap |
| trap_vec_o | output | 12 | Vector offset of the trap |
| slot_illegal_o | output | 1 | Branch-group instruction found in a delay slot |

## Verification
Random runs draw from every branch encoding and from non-branch filler. They use random T values, displacements at both sign extremes and random register operands, so that the taken and not-taken paths and the sign extension each show up on the fetch address. Directed sequences change `rn_val_i`, `pr_i` and `spc_i` during the delay slot, which separates sampling at branch time from sampling at redirect time. Other directed sequences place branches and traps inside a delay slot and insert idle cycles between a branch and its slot, which exposes any wrong update of PR, the trap request or the pending target.

// File: rtl/bnp_pkg.sv
package bnp_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_BC,    // conditional, immediate
    OP_BCS,   // conditional, delayed
    OP_BRA,   // pc-relative 12-bit
    OP_BRAF,  // pc + register
    OP_JMP,   // register absolute
    OP_RTS,
    OP_RTE,
    OP_TRAP
  } op_e;

  typedef struct packed {
    op_e         op;
    logic        want_t;
    logic        link;
    logic        delayed;
    logic        is_br;
    logic [3:0]  rn;
    logic [7:0]  imm8;
    logic [11:0] imm12;
  } dec_t;

endpackage

// File: rtl/bnp_decode.sv
module bnp_decode
  import bnp_pkg::*;
(
  input  logic [15:0] insn_i,
  output dec_t        dec_o
);

  always_comb begin
    dec_o         = '0;
    dec_o.op      = OP_NONE;
    dec_o.rn      = insn_i[11:8];
    dec_o.imm8    = insn_i[7:0];
    dec_o.imm12   = insn_i[11:0];
    casez (insn_i)
      16'b1000_1011_????_????: begin dec_o.op = OP_BC;  dec_o.want_t = 1'b0; end
      16'b1000_1001_????_????: begin dec_o.op = OP_BC;  dec_o.want_t = 1'b1; end
      16'b1000_1111_????_????: begin dec_o.op = OP_BCS; dec_o.want_t = 1'b0; end
      16'b1000_1101_????_????: begin dec_o.op = OP_BCS; dec_o.want_t = 1'b1; end
      16'b1010_????_????_????: dec_o.op = OP_BRA;
      16'b1011_????_????_????: begin dec_o.op = OP_BRA; dec_o.link = 1'b1; end
      16'b0000_????_0010_0011: dec_o.op = OP_BRAF;
      16'b0000_????_0000_0011: begin dec_o.op = OP_BRAF; dec_o.link = 1'b1; end
      16'b0100_????_0010_1011: dec_o.op = OP_JMP;
      16'b0100_????_0000_1011: begin dec_o.op = OP_JMP; dec_o.link = 1'b1; end
      16'h000B:                dec_o.op = OP_RTS;
      16'h002B:                dec_o.op = OP_RTE;
      16'b1100_0011_????_????: dec_o.op = OP_TRAP;
      default:                 dec_o.op = OP_NONE;
    endcase
    dec_o.is_br   = (dec_o.op != OP_NONE);
    dec_o.delayed = dec_o.is_br && (dec_o.op != OP_BC) && (dec_o.op != OP_TRAP);
  end

endmodule

// File: rtl/bnp_target.sv
module bnp_target
  import bnp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  dec_t            dec_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rn_val_i,
  input  logic [XLEN-1:0] pr_i,
  input  logic [XLEN-1:0] spc_i,
  output logic [XLEN-1:0] tgt_o
);

  localparam int S8  = XLEN - 9;
  localparam int S12 = XLEN - 13;

  logic [XLEN-1:0] pc4, off8, off12;

  assign pc4   = pc_i + XLEN'(4);
  assign off8  = {{S8{dec_i.imm8[7]}}, dec_i.imm8, 1'b0};
  assign off12 = {{S12{dec_i.imm12[11]}}, dec_i.imm12, 1'b0};

  always_comb begin
    unique case (dec_i.op)
      OP_BC, OP_BCS: tgt_o = pc4 + off8;
      OP_BRA:        tgt_o = pc4 + off12;
      OP_BRAF:       tgt_o = pc4 + rn_val_i;
      OP_JMP:        tgt_o = rn_val_i;
      OP_RTS:        tgt_o = pr_i;
      OP_RTE:        tgt_o = spc_i;
      default:       tgt_o = pc4;
    endcase
  end

endmodule

// File: rtl/bnp_pending.sv
module bnp_pending #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [XLEN-1:0] tgt_i,
  input  logic            clr_i,
  output logic            valid_o,
  output logic [XLEN-1:0] tgt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tgt_o   <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      tgt_o   <= tgt_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  // R11: a slot never queues a new target
  a_r11_set_excl_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i));

endmodule

// File: rtl/bnp_unit.sv
module bnp_unit
  import bnp_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_PC  = 32'hA000_0000,
  parameter logic [11:0]     TRAP_CODE = 12'h160,
  parameter logic [11:0]     TRAP_VEC  = 12'h100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            insn_valid_i,
  input  logic [15:0]     insn_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            t_i,
  input  logic [XLEN-1:0] rn_val_i,
  input  logic [XLEN-1:0] pr_i,
  input  logic [XLEN-1:0] spc_i,
  output logic [3:0]      rn_sel_o,
  output logic [XLEN-1:0] fetch_pc_o,
  output logic            pr_we_o,
  output logic [XLEN-1:0] pr_wdata_o,
  output logic            trap_req_o,
  output logic [XLEN-1:0] trap_tra_o,
  output logic [11:0]     trap_code_o,
  output logic [11:0]     trap_vec_o,
  output logic            slot_illegal_o
);

  dec_t            dec;
  logic [XLEN-1:0] tgt, pend_tgt, pc_seq;
  logic            pend_v, exec, slot, taken, defer, redirect_now;

  bnp_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  bnp_target #(.XLEN(XLEN)) u_tgt (
    .dec_i(dec), .pc_i(pc_i), .rn_val_i(rn_val_i),
    .pr_i(pr_i), .spc_i(spc_i), .tgt_o(tgt)
  );

  bnp_pending #(.XLEN(XLEN)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(defer), .tgt_i(tgt),
    .clr_i(slot), .valid_o(pend_v), .tgt_o(pend_tgt)
  );

  assign exec   = insn_valid_i && !pend_v;
  assign slot   = insn_valid_i && pend_v;
  assign pc_seq = pc_i + XLEN'(2);

  always_comb begin
    unique case (dec.op)
      OP_BC, OP_BCS: taken = (t_i == dec.want_t);
      OP_NONE, OP_TRAP: taken = 1'b0;
      default:       taken = 1'b1;
    endcase
  end

  assign defer        = exec && taken && dec.delayed;
  assign redirect_now = exec && taken && !dec.delayed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           fetch_pc_o <= RESET_PC;
    else if (slot)         fetch_pc_o <= pend_tgt;
    else if (redirect_now) fetch_pc_o <= tgt;
    else if (exec)         fetch_pc_o <= pc_seq;
  end

  assign rn_sel_o       = dec.rn;
  assign pr_we_o        = exec && dec.link;
  assign pr_wdata_o     = pc_i + XLEN'(4);
  assign trap_req_o     = exec && (dec.op == OP_TRAP);
  assign trap_tra_o     = {{(XLEN-10){1'b0}}, dec.imm8, 2'b00};
  assign trap_code_o    = TRAP_CODE;
  assign trap_vec_o     = TRAP_VEC;
  assign slot_illegal_o = slot && dec.is_br;

  // R2: sequential advance for non-branch work
  a_r2_seq_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && !pend_v && !dec.is_br) |=> fetch_pc_o == $past(pc_i) + XLEN'(2));

  // R4: slot acceptance redirects to the parked target
  a_r4_slot_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && pend_v) |=> (fetch_pc_o == $past(pend_tgt)) && !pend_v);

  // R11: side effects are mutually exclusive
  a_r11_side_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pr_we_o, trap_req_o, slot_illegal_o}));

  // R12: idle cycles hold fetch and pending state
  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_valid_i |=> $stable(fetch_pc_o) && $stable(pend_v));

endmodule

// File: tb/sim_bnp_unit.sv
module sim_bnp_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0;
  logic [15:0] insn = 16'h0009;
  logic [31:0] pc = '0, rn = '0, pr = '0, spc = '0;
  logic        t = 1'b0;
  logic [3:0]  rn_sel;
  logic [31:0] fetch_pc, pr_wdata, tra;
  logic        pr_we, trap_req, slot_ill;
  logic [11:0] tcode, tvec;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [31:0] m_fetch;
  bit          m_pv;
  logic [31:0] m_pt;

  always #10 clk = ~clk;

  bnp_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .insn_valid_i(v), .insn_i(insn), .pc_i(pc),
    .t_i(t), .rn_val_i(rn), .pr_i(pr), .spc_i(spc), .rn_sel_o(rn_sel),
    .fetch_pc_o(fetch_pc), .pr_we_o(pr_we), .pr_wdata_o(pr_wdata),
    .trap_req_o(trap_req), .trap_tra_o(tra), .trap_code_o(tcode),
    .trap_vec_o(tvec), .slot_illegal_o(slot_ill)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference decode from the requirement encodings
  function automatic void ref_dec(input logic [15:0] i, input logic [31:0] p,
      input logic tf, input logic [31:0] r, input logic [31:0] prv,
      input logic [31:0] sp, output bit isbr, output bit link, output bit dly,
      output bit trap, output bit tk, output logic [31:0] tg, output string tag);
    logic [31:0] d8, d12;
    d8  = {{23{i[7]}}, i[7:0], 1'b0};
    d12 = {{19{i[11]}}, i[11:0], 1'b0};
    isbr = 1; link = 0; dly = 1; trap = 0; tk = 1; tg = '0; tag = "R2";
    casez (i)
      16'b1000_1011_????_????: begin dly = 0; tk = !tf; tg = p + 4 + d8; tag = "R3"; end
      16'b1000_1001_????_????: begin dly = 0; tk = tf;  tg = p + 4 + d8; tag = "R3"; end
      16'b1000_1111_????_????: begin tk = !tf; tg = p + 4 + d8; tag = "R4"; end
      16'b1000_1101_????_????: begin tk = tf;  tg = p + 4 + d8; tag = "R4"; end
      16'b1010_????_????_????: begin tg = p + 4 + d12; tag = "R5"; end
      16'b1011_????_????_????: begin tg = p + 4 + d12; link = 1; tag = "R5"; end
      16'b0000_????_0010_0011: begin tg = r + p + 4; tag = "R6"; end
      16'b0000_????_0000_0011: begin tg = r + p + 4; link = 1; tag = "R6"; end
      16'b0100_????_0010_1011: begin tg = r; tag = "R7"; end
      16'b0100_????_0000_1011: begin tg = r; link = 1; tag = "R7"; end
      16'h000B:                begin tg = prv; tag = "R8"; end
      16'h002B:                begin tg = sp; tag = "R8"; end
      16'b1100_0011_????_????: begin dly = 0; tk = 0; trap = 1; tag = "R10"; end
      default:                 begin isbr = 0; dly = 0; tk = 0; end
    endcase
  endfunction

  task automatic step(string dtag, bit vv, logic [15:0] i, logic [31:0] p,
                      logic tf, logic [31:0] r, logic [31:0] prv, logic [31:0] sp);
    bit isbr, link, dly, trap, tk;
    logic [31:0] tg;
    string tag;
    @(negedge clk);
    v = vv; insn = i; pc = p; t = tf; rn = r; pr = prv; spc = sp;
    #1;
    ref_dec(i, p, tf, r, prv, sp, isbr, link, dly, trap, tk, tg, tag);
    if (dtag != "") tag = dtag;
    if (vv && m_pv) tag = isbr ? "R11" : "R4";
    chk({tag, " pr_we"}, 32'(pr_we), 32'(vv && !m_pv && link));
    if (vv && !m_pv && link) chk({tag, " pr_wdata"}, pr_wdata, p + 4);
    chk({tag, " trap_req"}, 32'(trap_req), 32'(vv && !m_pv && trap));
    if (vv && !m_pv && trap) begin
      chk("R10 tra", tra, {22'd0, i[7:0], 2'b00});
      chk("R10 code", 32'(tcode), 32'h160);
      chk("R10 vec", 32'(tvec), 32'h100);
    end
    chk({tag, " slot_illegal"}, 32'(slot_ill), 32'(vv && m_pv && isbr));
    chk("R6 rn_sel", 32'(rn_sel), 32'(i[11:8]));
    if (vv) begin
      if (m_pv) begin m_fetch = m_pt; m_pv = 0; end
      else if (tk && dly) begin m_pv = 1; m_pt = tg; m_fetch = p + 2; end
      else if (tk) m_fetch = tg;
      else m_fetch = p + 2;
    end
    @(posedge clk); #2;
    chk({tag, " fetch"}, fetch_pc, m_fetch);
  endtask

  function automatic logic [15:0] mk(int cls, logic [11:0] r12);
    case (cls)
      0:  return {4'h8, 4'hB, r12[7:0]};
      1:  return {4'h8, 4'h9, r12[7:0]};
      2:  return {4'h8, 4'hF, r12[7:0]};
      3:  return {4'h8, 4'hD, r12[7:0]};
      4:  return {4'hA, r12};
      5:  return {4'hB, r12};
      6:  return {4'h0, r12[3:0], 8'h23};
      7:  return {4'h0, r12[3:0], 8'h03};
      8:  return {4'h4, r12[3:0], 8'h2B};
      9:  return {4'h4, r12[3:0], 8'h0B};
      10: return 16'h000B;
      11: return 16'h002B;
      12: return {8'hC3, r12[7:0]};
      default: begin
        logic [3:0] hi;
        case ($urandom % 5) 0: hi = 4'h2; 1: hi = 4'h3; 2: hi = 4'h6; 3: hi = 4'h7; default: hi = 4'hE; endcase
        return {hi, r12};
      end
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_fetch = 32'hA000_0000; m_pv = 0; m_pt = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fetch", fetch_pc, 32'hA000_0000);
    chk("R1 pr_we", 32'(pr_we), 0);
    chk("R1 trap_req", 32'(trap_req), 0);
    chk("R1 slot_illegal", 32'(slot_ill), 0);
    rst_n = 1'b1;
    step("R12", 0, 16'h6003, 32'h1234, 0, 0, 0, 0);
    step("R2", 1, 16'h6003, 32'h0000_0100, 0, 0, 0, 0);
    step("R3", 1, 16'h89FF, 32'h0000_0100, 1, 0, 0, 0);   // -> 0x102
    step("R3", 1, 16'h8B80, 32'h0000_0200, 1, 0, 0, 0);   // not taken
    step("R3", 1, 16'h8B7F, 32'h0000_0200, 0, 0, 0, 0);   // max positive
    step("R4", 1, 16'h8D10, 32'h0000_0300, 0, 0, 0, 0);   // not taken
    step("R4", 1, 16'h8F10, 32'h0000_0300, 0, 0, 0, 0);   // taken, parked
    step("R12", 0, 16'hA000, 32'h0, 0, 0, 0, 0);          // idle holds pending
    step("R4", 1, 16'h6003, 32'h0000_0302, 0, 0, 0, 0);
    step("R5", 1, 16'hB800, 32'h0000_2000, 0, 0, 0, 0);   // min 12-bit, link
    step("R5", 1, 16'h6003, 32'h0000_2002, 0, 0, 0, 0);
    step("R6", 1, 16'h0703, 32'h0000_4000, 0, 32'h10, 0, 0);
    step("R9", 1, 16'h6003, 32'h0000_4002, 0, 32'hFFFF_0000, 0, 0);
    step("R7", 1, 16'h450B, 32'h0000_5000, 0, 32'h8000_0040, 0, 0);
    step("R9", 1, 16'h6003, 32'h0000_5002, 0, 32'h1111_1110, 0, 0);
    step("R8", 1, 16'h000B, 32'h0000_6000, 0, 0, 32'h0C00_0000, 0);
    step("R9", 1, 16'h6003, 32'h0000_6002, 0, 0, 32'h0D00_0000, 0);
    step("R8", 1, 16'h002B, 32'h0000_7000, 0, 0, 0, 32'h0E00_0010);
    step("R9", 1, 16'h6003, 32'h0000_7002, 0, 0, 0, 32'h0);
    step("R10", 1, 16'hC3FF, 32'h0000_8000, 0, 0, 0, 0);
    step("R7", 1, 16'h420B, 32'h0000_9000, 0, 32'h0000_A000, 0, 0);
    step("R11", 1, 16'hB123, 32'h0000_9002, 0, 0, 0, 0); // call in slot
    step("R5", 1, 16'hA010, 32'h0000_A000, 0, 0, 0, 0);
    step("R11", 1, 16'hC301, 32'h0000_A002, 0, 0, 0, 0); // trap in slot
    step("R2", 1, 16'h6003, 32'h0000_A024, 0, 0, 0, 0);  // nothing pending after
    for (int k = 0; k < 3000; k++) begin
      int cls = $urandom % 20;
      logic [11:0] r12 = 12'($urandom);
      logic [31:0] p = ($urandom % 4 != 0) ? m_fetch : {$urandom, 1'b0};
      if ($urandom % 8 == 0) r12 = ($urandom % 2) ? 12'h800 : 12'h7FF;
      step("", ($urandom % 10) != 0, mk(cls, r12), p, 1'($urandom),
           $urandom, $urandom, $urandom);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule